// File: doc/BRIEF.md
# Presence-Tracking Coherence Directory

This block is a tag-only directory that sits beside the private caches of several cores and keeps track of which cores might hold each line. Each entry pairs a line tag with a presence vector that has one bit per core. The directory stores no line data. When a core needs write ownership, the directory sends invalidation strobes only to the other cores whose presence bit is set. It does not broadcast to every core. Presence is conservative: a set bit may be stale, but a core that holds a line always has its bit set.

The directory is set-associative and inclusive of the private caches. When a new line misses in a full set, the least recently used entry is displaced. Every core still marked present in that entry is then back-invalidated before the new line is installed. Displacement can therefore hit a line that is in heavy use inside some core's private cache.

Cores send read requests, read-exclusive requests and eviction notices. The directory serves one request at a time. While invalidations are outstanding it raises `busy`, and it finishes each serviced request with a one-cycle grant.

Top module: `snoop_dir`

## Requirements
- R1: A read request (req_op = 0) to a line that needs no displacement is granted in the cycle after acceptance. `grant` is high for one cycle with `grant_core`/`grant_addr` naming the request, no strobe is raised, and the requester is recorded as present.
- R2: A read-exclusive request (req_op = 1) to a tracked line raises strobes for exactly the other cores recorded as present. The requester is never included. `inv_addr` carries the requested line address and stays stable while the strobes are pending.
- R3: Each strobe stays high until its own `inv_ack` bit is sampled, and an acknowledgement drops only that core's strobe. `grant` follows only after every targeted core has acknowledged, in the cycle after the last acknowledgement, and no strobe is high while `grant` is high.
- R4: Once a read-exclusive request completes, only the requester is recorded as present for that line.
- R5: `busy` is high exactly while strobes are pending. A request presented while `busy` is high is not accepted and leaves no record.
- R6: An eviction notice (req_op = 2) clears the sending core's presence bit and produces no grant. A notice for an untracked line has no effect.
- R7: An entry whose presence vector becomes all-zero is freed. A later miss in that set fills the freed way without any back-invalidation.
- R8: A miss in a full set displaces the victim entry. The victim's address goes out on `inv_addr`, and strobes are raised for every core present in the victim. The new line is granted after the acknowledgements, and the displaced line is no longer tracked.
- R9: The victim is the least recently used way of the set, and any read or read-exclusive hit refreshes that entry's recency.
- R10: The set is selected by the low log2(NSETS) bits of the line address. Lines in different sets never displace each other.
- R11: After reset the directory is empty: no strobe, no grant, and `busy` low.
- R12: A read-exclusive request from the only core recorded as present is granted in the next cycle without any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted on a clock edge when `busy` is low |
| req_op | input | 2 | 0 read, 1 read-exclusive, 2 eviction notice, 3 no operation |
| req_core | input | log2(NCORES) | Requesting core |
| req_addr | input | ADDR_W | Line address |
| busy | output | 1 | Waiting for invalidation acknowledgements |
| inv_valid | output | NCORES | Per-core invalidation strobes |
| inv_addr | output | ADDR_W | Line address being invalidated |
| inv_ack | input | NCORES | Per-core invalidation acknowledgements |
| grant | output | 1 | One-cycle completion of a read or read-exclusive request |
| grant_core | output | log2(NCORES) | Core that is granted |
| grant_addr | output | ADDR_W | Line that is granted |

## Verification
The bench builds the block with its defaults: 4 cores, 8 sets, 4 ways and 16-bit line addresses. With only four ways, five lines that share an index overflow a set after a handful of requests. That exercises the replacement order, back-invalidation of a displaced line, and a fill into a freed way. With four cores the bench can hold mixed sharer sets, so strobes go to several targets at once and are acknowledged one by one. A line in a different set is kept live across the overflow to show that sets are independent.

// File: rtl/sf_pkg.sv
package sf_pkg;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_RDX   = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } sf_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } sf_st_e;

endpackage

// File: rtl/sf_way_match.sv
module sf_way_match #(
    parameter int NWAYS = 4,
    parameter int TAG_W = 13
) (
    input  logic [NWAYS-1:0]            vld_i,
    input  logic [NWAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic                        hit_o,
    output logic [$clog2(NWAYS)-1:0]    way_o
);
    localparam int WAY_W = $clog2(NWAYS);

    logic [NWAYS-1:0] match;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign match[w] = vld_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        hit_o = |match;
        way_o = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (match[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sf_victim_sel.sv
module sf_victim_sel #(
    parameter int NWAYS = 4
) (
    input  logic [NWAYS-1:0]                    vld_i,
    input  logic [NWAYS-1:0][$clog2(NWAYS)-1:0] age_i,
    output logic                                has_free_o,
    output logic [$clog2(NWAYS)-1:0]            free_way_o,
    output logic [$clog2(NWAYS)-1:0]            old_way_o
);
    localparam int WAY_W = $clog2(NWAYS);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NWAYS - 1);

    always_comb begin
        has_free_o = ~&vld_i;
        free_way_o = '0;
        old_way_o  = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (!vld_i[w]) free_way_o = WAY_W'(w);
            if (age_i[w] == OLDEST) old_way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sf_age_touch.sv
module sf_age_touch #(
    parameter int NWAYS = 4
) (
    input  logic [NWAYS-1:0][$clog2(NWAYS)-1:0] age_i,
    input  logic [$clog2(NWAYS)-1:0]            way_i,
    output logic [NWAYS-1:0][$clog2(NWAYS)-1:0] age_o
);
    localparam int WAY_W = $clog2(NWAYS);

    logic [WAY_W-1:0] ref_age;
    assign ref_age = age_i[way_i];

    for (genvar w = 0; w < NWAYS; w++) begin : g_age
        always_comb begin
            if (way_i == WAY_W'(w))       age_o[w] = '0;
            else if (age_i[w] < ref_age)  age_o[w] = age_i[w] + 1'b1;
            else                          age_o[w] = age_i[w];
        end
    end
endmodule

// File: rtl/snoop_dir.sv
module snoop_dir
    import sf_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NSETS  = 8,
    parameter int NWAYS  = 4,
    parameter int ADDR_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_op,
    input  logic [$clog2(NCORES)-1:0] req_core,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      busy,
    output logic [NCORES-1:0]         inv_valid,
    output logic [ADDR_W-1:0]         inv_addr,
    input  logic [NCORES-1:0]         inv_ack,
    output logic                      grant,
    output logic [$clog2(NCORES)-1:0] grant_core,
    output logic [ADDR_W-1:0]         grant_addr
);
    localparam int CID_W = $clog2(NCORES);
    localparam int IDX_W = $clog2(NSETS);
    localparam int WAY_W = $clog2(NWAYS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [NSETS-1:0][NWAYS-1:0]             vld;
        logic [NSETS-1:0][NWAYS-1:0][TAG_W-1:0]  tag;
        logic [NSETS-1:0][NWAYS-1:0][NCORES-1:0] pres;
        logic [NSETS-1:0][NWAYS-1:0][WAY_W-1:0]  age;
        sf_st_e                                  st;
        logic [NCORES-1:0]                       inv;
        logic [ADDR_W-1:0]                       inv_addr;
        logic [IDX_W-1:0]                        p_set;
        logic [WAY_W-1:0]                        p_way;
        logic [TAG_W-1:0]                        p_tag;
        logic [NCORES-1:0]                       p_pres;
        logic [CID_W-1:0]                        p_core;
        logic [ADDR_W-1:0]                       p_addr;
        logic                                    grant;
        logic [CID_W-1:0]                        g_core;
        logic [ADDR_W-1:0]                       g_addr;
    } state_t;

    state_t s_q, s_d;

    // request decode
    sf_op_e            op;
    logic [IDX_W-1:0]  r_set;
    logic [TAG_W-1:0]  r_tag;
    logic [NCORES-1:0] r_me;
    logic              accept;

    assign op     = sf_op_e'(req_op);
    assign r_set  = req_addr[IDX_W-1:0];
    assign r_tag  = req_addr[ADDR_W-1:IDX_W];
    assign r_me   = NCORES'(1) << req_core;
    assign accept = req_valid && (s_q.st == ST_IDLE);

    // set lookup
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             has_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;

    sf_way_match #(.NWAYS(NWAYS), .TAG_W(TAG_W)) u_match (
        .vld_i  (s_q.vld[r_set]),
        .tags_i (s_q.tag[r_set]),
        .tag_i  (r_tag),
        .hit_o  (hit),
        .way_o  (hit_way)
    );

    sf_victim_sel #(.NWAYS(NWAYS)) u_vict (
        .vld_i      (s_q.vld[r_set]),
        .age_i      (s_q.age[r_set]),
        .has_free_o (has_free),
        .free_way_o (free_way),
        .old_way_o  (old_way)
    );

    logic [WAY_W-1:0]  alloc_way;
    logic [NCORES-1:0] vict_pres;
    logic              vict_live;
    logic [NCORES-1:0] others;
    logic [NCORES-1:0] rem;

    assign alloc_way = has_free ? free_way : old_way;
    assign vict_pres = s_q.pres[r_set][alloc_way];
    assign vict_live = s_q.vld[r_set][alloc_way] && (vict_pres != '0);
    assign others    = s_q.pres[r_set][hit_way] & ~r_me;
    assign rem       = s_q.inv & ~inv_ack;

    // action decision
    logic              t_en;
    logic [IDX_W-1:0]  t_set;
    logic [WAY_W-1:0]  t_way;
    logic              go_wait;
    logic [NCORES-1:0] wait_mask;
    logic [ADDR_W-1:0] wait_addr;
    logic [WAY_W-1:0]  wait_way;
    logic              inst_now;
    logic              or_now;
    logic              own_now;
    logic              drop_now;

    always_comb begin
        t_en      = 1'b0;
        t_set     = r_set;
        t_way     = hit_way;
        go_wait   = 1'b0;
        wait_mask = '0;
        wait_addr = req_addr;
        wait_way  = hit_way;
        inst_now  = 1'b0;
        or_now    = 1'b0;
        own_now   = 1'b0;
        drop_now  = 1'b0;
        if (s_q.st == ST_WAIT) begin
            t_set = s_q.p_set;
            t_way = s_q.p_way;
            t_en  = (rem == '0);
        end else if (accept) begin
            unique case (op)
                OP_RD, OP_RDX: begin
                    if (hit) begin
                        if (op == OP_RD) begin
                            or_now = 1'b1;
                            t_en   = 1'b1;
                        end else if (others == '0) begin
                            own_now = 1'b1;
                            t_en    = 1'b1;
                        end else begin
                            go_wait   = 1'b1;
                            wait_mask = others;
                        end
                    end else if (vict_live) begin
                        go_wait   = 1'b1;
                        wait_mask = vict_pres;
                        wait_addr = {s_q.tag[r_set][alloc_way], r_set};
                        wait_way  = alloc_way;
                    end else begin
                        inst_now = 1'b1;
                        t_en     = 1'b1;
                        t_way    = alloc_way;
                    end
                end
                OP_EVICT: drop_now = hit;
                default: ;
            endcase
        end
    end

    logic [NWAYS-1:0][WAY_W-1:0] aged;

    sf_age_touch #(.NWAYS(NWAYS)) u_age (
        .age_i (s_q.age[t_set]),
        .way_i (t_way),
        .age_o (aged)
    );

    // next state
    always_comb begin
        s_d       = s_q;
        s_d.grant = 1'b0;
        if (t_en) s_d.age[t_set] = aged;

        if (s_q.st == ST_WAIT) begin
            s_d.inv = rem;
            if (rem == '0) begin
                s_d.vld[s_q.p_set][s_q.p_way]  = 1'b1;
                s_d.tag[s_q.p_set][s_q.p_way]  = s_q.p_tag;
                s_d.pres[s_q.p_set][s_q.p_way] = s_q.p_pres;
                s_d.st     = ST_IDLE;
                s_d.grant  = 1'b1;
                s_d.g_core = s_q.p_core;
                s_d.g_addr = s_q.p_addr;
            end
        end else begin
            if (or_now) s_d.pres[r_set][hit_way] = s_q.pres[r_set][hit_way] | r_me;
            if (own_now) s_d.pres[r_set][hit_way] = r_me;
            if (inst_now) begin
                s_d.vld[r_set][alloc_way]  = 1'b1;
                s_d.tag[r_set][alloc_way]  = r_tag;
                s_d.pres[r_set][alloc_way] = r_me;
            end
            if (drop_now) begin
                s_d.pres[r_set][hit_way] = s_q.pres[r_set][hit_way] & ~r_me;
                if ((s_q.pres[r_set][hit_way] & ~r_me) == '0)
                    s_d.vld[r_set][hit_way] = 1'b0;
            end
            if (or_now || own_now || inst_now) begin
                s_d.grant  = 1'b1;
                s_d.g_core = req_core;
                s_d.g_addr = req_addr;
            end
            if (go_wait) begin
                s_d.st       = ST_WAIT;
                s_d.inv      = wait_mask;
                s_d.inv_addr = wait_addr;
                s_d.p_set    = r_set;
                s_d.p_way    = wait_way;
                s_d.p_tag    = r_tag;
                s_d.p_pres   = r_me;
                s_d.p_core   = req_core;
                s_d.p_addr   = req_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int s = 0; s < NSETS; s++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    s_q.age[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.st == ST_WAIT);
    assign inv_valid  = s_q.inv;
    assign inv_addr   = s_q.inv_addr;
    assign grant      = s_q.grant;
    assign grant_core = s_q.g_core;
    assign grant_addr = s_q.g_addr;
endmodule

// File: rtl/snoop_dir_chk.sv
module snoop_dir_chk #(
    parameter int NCORES = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [NCORES-1:0] inv_valid,
    input logic [ADDR_W-1:0] inv_addr,
    input logic [NCORES-1:0] inv_ack,
    input logic              grant
);
    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_valid & ~inv_ack) != '0) |=>
        ((inv_valid & $past(inv_valid & ~inv_ack)) == $past(inv_valid & ~inv_ack))); // R3

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_valid & inv_ack) != '0) |=>
        ((inv_valid & $past(inv_valid & inv_ack)) == '0)); // R3

    AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (!busy && inv_valid == '0)); // R3

    AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (inv_valid != '0)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (inv_valid == '0)); // R5

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(inv_addr)); // R2
endmodule

bind snoop_dir snoop_dir_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .inv_valid (inv_valid),
    .inv_addr  (inv_addr),
    .inv_ack   (inv_ack),
    .grant     (grant)
);

// File: tb/sim_snoop_dir.sv
module sim_snoop_dir;
    localparam int NC = 4;
    localparam int NS = 8;
    localparam int NW = 4;
    localparam int AW = 16;
    localparam int RD = 0, RDX = 1, EVN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [1:0]    req_core = '0;
    logic [AW-1:0] req_addr = '0;
    logic          busy;
    logic [NC-1:0] inv_valid;
    logic [AW-1:0] inv_addr;
    logic [NC-1:0] inv_ack = '0;
    logic          grant;
    logic [1:0]    grant_core;
    logic [AW-1:0] grant_addr;

    snoop_dir #(.NCORES(NC), .NSETS(NS), .NWAYS(NW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_core(req_core), .req_addr(req_addr), .busy(busy),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
        .grant(grant), .grant_core(grant_core), .grant_addr(grant_addr)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned exp_q[$];

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int mk(input int tag, input int set);
        return (tag << 3) | set;
    endfunction

    // monitor: pops expected grants
    always @(negedge clk) begin
        if (rst_n && grant) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected grant", {grant_core, grant_addr}, 0);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                check({14'd0, grant_core, grant_addr} == e, "R1", "grant core/addr",
                      {grant_core, grant_addr}, int'(e));
            end
        end
    end

    task automatic send(input int op, input int core, input int addr);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_core  = 2'(core);
        req_addr  = AW'(addr);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_inv(input int mask, input int addr, input string rq);
        check(int'(inv_valid) == mask, rq, "strobes", int'(inv_valid), mask);
        check(busy == (mask != 0), rq, "busy", int'(busy), int'(mask != 0));
        if (mask != 0)
            check(int'(inv_addr) == addr, rq, "inv_addr", int'(inv_addr), addr);
    endtask

    task automatic ack_all(input int mask, input string rq);
        int remain = mask;
        for (int c = 0; c < NC; c++) begin
            if (mask[c]) begin
                inv_ack = NC'(1) << c;
                @(negedge clk);
                inv_ack = '0;
                remain &= ~(1 << c);
                check(int'(inv_valid) == remain, rq, "strobes after ack",
                      int'(inv_valid), remain);
                check(busy == (remain != 0), rq, "busy after ack",
                      int'(busy), int'(remain != 0));
            end
        end
    endtask

    task automatic rq(input int op, input int core, input int addr,
                      input int mask, input int iaddr, input string tagname);
        if (op != EVN) exp_q.push_back((core << 16) | addr);
        send(op, core, addr);
        expect_inv(mask, iaddr, tagname);
        if (mask != 0) ack_all(mask, tagname);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int a, b, x, s3, l0, l1, l2, l3, l4, l5;
        a  = mk(1, 0);
        b  = mk(9, 5);
        x  = mk(3, 1);
        s3 = mk(6, 3);
        l0 = mk(1, 2); l1 = mk(2, 2); l2 = mk(3, 2);
        l3 = mk(4, 2); l4 = mk(5, 2); l5 = mk(7, 2);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(inv_valid == '0, "R11", "strobes after reset", int'(inv_valid), 0);
        check(!busy, "R11", "busy after reset", int'(busy), 0);
        check(!grant, "R11", "grant after reset", int'(grant), 0);

        // R1 reads from three cores
        rq(RD, 0, a, 0, 0, "R1");
        rq(RD, 1, a, 0, 0, "R1");
        rq(RD, 2, a, 0, 0, "R1");
        // R2 R3 readx targets the three sharers only
        rq(RDX, 3, a, 4'b0111, a, "R2");
        // R4 only previous owner invalidated
        rq(RDX, 0, a, 4'b1000, a, "R4");
        // R12 sole holder
        rq(RDX, 0, a, 0, 0, "R12");
        // R6 eviction notice clears one bit
        rq(RD, 1, a, 0, 0, "R1");
        rq(EVN, 1, a, 0, 0, "R6");
        rq(RDX, 2, a, 4'b0001, a, "R6");
        // R6 untracked notice ignored
        rq(EVN, 0, b, 0, 0, "R6");
        rq(RD, 0, b, 0, 0, "R6");

        // R5 request while busy is ignored
        exp_q.push_back((3 << 16) | a);
        send(RDX, 3, a);
        expect_inv(4'b0100, a, "R5");
        req_valid = 1'b1; req_op = 2'(RD); req_core = 2'd1; req_addr = AW'(x);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy, "R5", "busy holds during stray", int'(busy), 1);
        check(int'(inv_valid) == 4'b0100, "R5", "strobes during stray", int'(inv_valid), 4);
        ack_all(4'b0100, "R5");
        rq(RDX, 2, x, 0, 0, "R5");

        // R10 line in set 3 kept across set 2 activity
        rq(RD, 0, s3, 0, 0, "R10");
        // fill set 2
        rq(RD, 0, l0, 0, 0, "R7");
        rq(RD, 1, l1, 0, 0, "R7");
        rq(RD, 2, l2, 0, 0, "R7");
        rq(RD, 3, l3, 0, 0, "R7");
        // R9 hit refreshes l0, l1 becomes victim
        rq(RD, 1, l0, 0, 0, "R9");
        rq(RD, 3, l4, 4'b0010, l1, "R8");
        // R8 displaced l1 untracked: victim now l2
        rq(RDX, 0, l1, 4'b0100, l2, "R8");
        // R7 freed entry reused without back-invalidation
        rq(EVN, 3, l3, 0, 0, "R7");
        rq(RD, 2, l5, 0, 0, "R7");
        // R10 set 3 line still tracked by core 0
        rq(RDX, 1, s3, 4'b0001, s3, "R10");

        @(negedge clk);
        check(exp_q.size() == 0, "R1", "grants outstanding", exp_q.size(), 0);
        finish_run();
    end
endmodule